// File: doc/BRIEF.md
# Processor Stop-Clock Power State Controller

This block sequences one processor core through its power-saving states, clocked by the bus clock. Logical processors report halts with strobes. Once every logical processor has halted, the core drops into a plain halt state, or into a deep halt state that also selects the low operating point. Asserting the active-low stop-clock input starts a handshake. The controller requests a stop-grant acknowledge bus cycle once per logical processor. After the last response phase it counts a fixed number of bus clocks and then enters Stop Grant. From Stop Grant, the sleep input moves the core into Sleep and back again.

In the halt and Stop Grant states the controller drops the clock-gate enable. A snoop in a halt or grant state moves to a matching snoop state, which reopens the clock until the snoop is serviced. Wake events arriving during Stop Grant are held as one pending bit per event type. While any bit is held, a break-event flag is raised, and the held bits are handed out as a single pulse when the core returns to the running state. Misuse of the stop-clock or sleep protocol produces a one-cycle error pulse.

Top module: `stopclk_pm_ctrl`

## Requirements
- R1: After the block reset (`rst_n` low), the state is RUN, `clk_en` is 1, and `ack_req`, `low_op`, `brk_pend`, `evt_out` and `proto_err` are all 0. State codes: RUN=0, HALT=1, DHALT=2, HALT_SNP=3, DHALT_SNP=4, GRANT=5, GRANT_SNP=6, SLEEP=7.
- R2: In RUN, each `halt_req` bit sets its bit in `halt_mask`, and the state stays RUN while any logical processor is still running. On the edge that completes the mask, the state becomes HALT (`deep_halt_en`=0) or DHALT (`deep_halt_en`=1).
- R3: In HALT or DHALT, any `wake_evt` bit returns the state to RUN on the next edge and clears `halt_mask`.
- R4: In HALT or DHALT, `snoop_start` moves to HALT_SNP or DHALT_SNP respectively. The state stays there until `snoop_done`, then returns to the halt state it came from.
- R5: `clk_en` is 0 in HALT, DHALT, GRANT and SLEEP and 1 in RUN and in every snoop state. `low_op` is 1 only in DHALT and DHALT_SNP.
- R6: When `stop_clk_n` is low in RUN, HALT or DHALT, `ack_req` rises after the next edge. It stays high until NUM_LP responses have been counted on `ack_resp`.
- R7: GRANT is entered exactly GRANT_DELAY (20) edges after the edge that samples the final `ack_resp`, and never earlier.
- R8: `stop_clk_n` high in GRANT leaves GRANT. The state goes to HALT or DHALT if every logical processor is halted and no event is pending; otherwise it goes to RUN.
- R9: `stop_clk_n` rising while the handshake or countdown is still running raises `proto_err` for one cycle. The countdown still completes on time.
- R10: In GRANT and GRANT_SNP, wake events are held as one bit per type: bit 0 SMI, bit 1 INIT, bit 2 BINIT, bit 3 LINT, bit 4 bus interrupt. `brk_pend` is 1 while any bit is held. On return to RUN, `evt_out` carries the held bits for exactly one cycle.
- R11: In GRANT, `snoop_start` moves to GRANT_SNP, and `snoop_done` returns to GRANT.
- R12: `sleep_n` low in GRANT enters SLEEP, and `sleep_n` high in SLEEP returns to GRANT. Raising `stop_clk_n` one clock after that return is legal and reaches RUN.
- R13: In SLEEP with `core_reset_n` high, any strobe input or `stop_clk_n` high raises `proto_err` for one cycle, and the state stays SLEEP.
- R14: `core_reset_n` low in GRANT or GRANT_SNP keeps the state in GRANT and clears held events. In any other state, including SLEEP, it goes straight to RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| halt_req | input | NUM_LP | Per-logical-processor halt strobe |
| deep_halt_en | input | 1 | Selects deep halt with low operating point |
| stop_clk_n | input | 1 | Active-low stop-clock request |
| sleep_n | input | 1 | Active-low sleep request |
| core_reset_n | input | 1 | Active-low core reset pin |
| snoop_start | input | 1 | Snoop or interrupt transaction begins |
| snoop_done | input | 1 | Snoop serviced or interrupt latched |
| wake_evt | input | 5 | Event strobes (SMI, INIT, BINIT, LINT, bus interrupt) |
| ack_resp | input | 1 | Response phase of a stop-grant acknowledge cycle |
| state | output | 3 | Current power state code |
| halt_mask | output | NUM_LP | Halted logical processors |
| ack_req | output | 1 | Request to issue the acknowledge cycle |
| clk_en | output | 1 | Core clock-gate enable |
| low_op | output | 1 | Low operating point select |
| brk_pend | output | 1 | Pending break-event flag |
| evt_out | output | 5 | Held events handed out on return to RUN |
| proto_err | output | 1 | Protocol misuse pulse |

## Verification
Every result is registered at the edge that samples its cause. `state`, `halt_mask`, `ack_req`, `brk_pend`, `evt_out` and `proto_err` are therefore valid one edge after the stimulus. GRANT is the one delayed result, due GRANT_DELAY edges after the final response. The bench changes inputs and reads outputs 1 ns after a rising edge. It counts edges explicitly: it confirms the state is not yet GRANT one edge before the deadline and is GRANT at the deadline. The one-cycle pulses are checked both on their cycle and on the cycle after, where they must be 0.

// File: rtl/stopclk_pm_pkg.sv
// Shared types for the stop-clock power state controller.
// Assumes a 3-bit state code that is visible at the top-level port.
package stopclk_pm_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_HALT      = 3'd1,
        ST_DHALT     = 3'd2,
        ST_HALT_SNP  = 3'd3,
        ST_DHALT_SNP = 3'd4,
        ST_GRANT     = 3'd5,
        ST_GRANT_SNP = 3'd6,
        ST_SLEEP     = 3'd7
    } pm_state_e;

    localparam int EVT_W = 5;

    // True in the two states where wake events are held rather than served
    function automatic logic is_grant(pm_state_e s);
        return (s == ST_GRANT) || (s == ST_GRANT_SNP);
    endfunction

    // True in the states from which a stop-clock handshake may start or finish
    function automatic logic is_armable(pm_state_e s);
        return (s == ST_RUN) || (s == ST_HALT) || (s == ST_DHALT);
    endfunction

endpackage

// File: rtl/stopclk_grant_timer.sv
// Stop-grant handshake: arms on stop-clock assertion, requests one
// acknowledge cycle per logical processor, then counts GRANT_DELAY clocks
// after the final response before firing. While fire_ok is low the count
// holds at its last step. Also flags stop-clock released mid-handshake.
// Assumes ack_resp is a single-cycle strobe.
module stopclk_grant_timer #(
    parameter int NUM_LP      = 2,
    parameter int GRANT_DELAY = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_clk_n,
    input  logic core_reset_n,
    input  logic arm_ok,
    input  logic fire_ok,
    input  logic ack_resp,
    output logic ack_req,
    output logic grant_fire,
    output logic early_err
);
    localparam int RC_W  = $clog2(NUM_LP + 1);
    localparam int CNT_W = $clog2(GRANT_DELAY + 1);

    logic             seq_active;
    logic [RC_W-1:0]  resp_cnt;
    logic [CNT_W-1:0] cnt;
    logic             stop_q;
    logic             last_resp;

    assign ack_req    = seq_active && (resp_cnt < RC_W'(NUM_LP));
    assign last_resp  = ack_req && ack_resp && (resp_cnt == RC_W'(NUM_LP - 1));
    assign grant_fire = (cnt == CNT_W'(1)) && fire_ok;

    // Handshake progress, response count and entry countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_active <= 1'b0;
            resp_cnt   <= '0;
            cnt        <= '0;
            stop_q     <= 1'b1;
            early_err  <= 1'b0;
        end else begin
            stop_q    <= stop_clk_n;
            early_err <= seq_active && stop_clk_n && !stop_q;
            if (!core_reset_n || grant_fire) begin
                seq_active <= 1'b0;
                resp_cnt   <= '0;
                cnt        <= '0;
            end else begin
                if (!seq_active && !stop_clk_n && arm_ok) begin
                    seq_active <= 1'b1;
                end
                if (ack_req && ack_resp) begin
                    resp_cnt <= resp_cnt + 1'b1;
                    if (last_resp) begin
                        cnt <= CNT_W'(GRANT_DELAY);
                    end
                end else if (cnt > CNT_W'(1)) begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // R7
    fire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_fire |=> !grant_fire);

    // R6
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_fire |=> !ack_req);

endmodule

// File: rtl/stopclk_event_latch.sv
// Holds one pending bit per wake-event type while the core is granted.
// Hands the held bits out as a one-cycle pulse on return to run, and
// raises the break-event flag while anything is held. The core reset
// pin discards held events.
module stopclk_event_latch #(
    parameter int EVT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_reset_n,
    input  logic             latch_en,
    input  logic             deliver,
    input  logic [EVT_W-1:0] wake_evt,
    output logic             pend_any,
    output logic             brk_pend,
    output logic [EVT_W-1:0] evt_out
);
    logic [EVT_W-1:0] pend;

    assign pend_any = |pend;
    assign brk_pend = latch_en && pend_any;

    // Pending set, delivery pulse and clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= '0;
            evt_out <= '0;
        end else begin
            evt_out <= '0;
            if (!core_reset_n) begin
                pend <= '0;
            end else if (deliver) begin
                evt_out <= pend | wake_evt;
                pend    <= '0;
            end else if (latch_en) begin
                pend <= pend | wake_evt;
            end
        end
    end

    // R10
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && core_reset_n && !deliver && (|wake_evt)) |=> (|pend));

    // R10
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_out) |=> (evt_out == '0));

endmodule

// File: rtl/stopclk_state_fsm.sv
// Power state register and next-state logic. Tracks which logical
// processors have halted, routes snoops to the matching snoop state,
// handles sleep and the core reset pin, and flags illegal input activity
// in sleep. Assumes all strobes are single-cycle and that grant_fire comes
// from the handshake timer.
module stopclk_state_fsm
    import stopclk_pm_pkg::*;
#(
    parameter int NUM_LP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_LP-1:0] halt_req,
    input  logic              deep_halt_en,
    input  logic              stop_clk_n,
    input  logic              sleep_n,
    input  logic              core_reset_n,
    input  logic              snoop_start,
    input  logic              snoop_done,
    input  logic [EVT_W-1:0]  wake_evt,
    input  logic              ack_resp,
    input  logic              grant_fire,
    input  logic              pend_any,
    output pm_state_e         state,
    output logic [NUM_LP-1:0] halt_mask,
    output logic              deliver,
    output logic              sleep_err
);
    pm_state_e state_nxt;
    pm_state_e halt_tgt;
    logic      all_halt;
    logic      all_halt_nxt;
    logic      any_evt;
    logic      wake_back;
    logic      mask_clr;
    logic      sleep_noise;

    assign all_halt     = &halt_mask;
    assign all_halt_nxt = &(halt_mask | halt_req);
    assign any_evt      = |wake_evt;
    assign halt_tgt     = deep_halt_en ? ST_DHALT : ST_HALT;
    assign wake_back    = pend_any || any_evt || !all_halt;
    assign sleep_noise  = stop_clk_n || snoop_start || snoop_done || any_evt
                          || (|halt_req) || ack_resp;

    // Next-state selection, with the core reset pin overriding last
    always_comb begin
        state_nxt = state;
        case (state)
            ST_RUN: begin
                if (grant_fire)        state_nxt = ST_GRANT;
                else if (all_halt_nxt) state_nxt = halt_tgt;
            end
            ST_HALT, ST_DHALT: begin
                if (any_evt)           state_nxt = ST_RUN;
                else if (grant_fire)   state_nxt = ST_GRANT;
                else if (snoop_start)  state_nxt = (state == ST_HALT) ? ST_HALT_SNP : ST_DHALT_SNP;
            end
            ST_HALT_SNP: begin
                if (snoop_done)        state_nxt = ST_HALT;
            end
            ST_DHALT_SNP: begin
                if (snoop_done)        state_nxt = ST_DHALT;
            end
            ST_GRANT: begin
                if (stop_clk_n)        state_nxt = wake_back ? ST_RUN : halt_tgt;
                else if (!sleep_n)     state_nxt = ST_SLEEP;
                else if (snoop_start)  state_nxt = ST_GRANT_SNP;
            end
            ST_GRANT_SNP: begin
                if (snoop_done)        state_nxt = ST_GRANT;
            end
            ST_SLEEP: begin
                if (sleep_n)           state_nxt = ST_GRANT;
            end
            default:                   state_nxt = ST_RUN;
        endcase
        if (!core_reset_n) begin
            state_nxt = is_grant(state) ? ST_GRANT : ST_RUN;
        end
    end

    assign deliver  = (state == ST_GRANT) && (state_nxt == ST_RUN);
    assign mask_clr = !core_reset_n
                      || (((state == ST_HALT) || (state == ST_DHALT)) && (state_nxt == ST_RUN))
                      || (deliver && (pend_any || any_evt));

    // State, halt mask and sleep misuse flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            halt_mask <= '0;
            sleep_err <= 1'b0;
        end else begin
            state     <= state_nxt;
            sleep_err <= (state == ST_SLEEP) && core_reset_n && sleep_noise;
            if (mask_clr) begin
                halt_mask <= '0;
            end else if (state == ST_RUN) begin
                halt_mask <= halt_mask | halt_req;
            end
        end
    end

    // R12
    sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SLEEP) && core_reset_n) |=> ((state == ST_SLEEP) || (state == ST_GRANT)));

    // R7
    no_early_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_armable(state) && !grant_fire) |=> (state != ST_GRANT));

    // R4
    snoop_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DHALT_SNP) |=> ((state == ST_DHALT_SNP) || (state == ST_DHALT) || (state == ST_RUN)));

    // R14
    reset_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_grant(state) && !core_reset_n) |=> (state == ST_GRANT));

endmodule

// File: rtl/stopclk_pm_ctrl.sv
// Top of the stop-clock power state controller. Joins the state machine,
// the grant handshake timer and the event latch, and decodes the clock
// gate and operating point selects from the registered state.
// Assumes every input is synchronous to the bus clock.
module stopclk_pm_ctrl
    import stopclk_pm_pkg::*;
#(
    parameter int NUM_LP      = 2,
    parameter int GRANT_DELAY = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_LP-1:0] halt_req,
    input  logic              deep_halt_en,
    input  logic              stop_clk_n,
    input  logic              sleep_n,
    input  logic              core_reset_n,
    input  logic              snoop_start,
    input  logic              snoop_done,
    input  logic [EVT_W-1:0]  wake_evt,
    input  logic              ack_resp,
    output logic [2:0]        state,
    output logic [NUM_LP-1:0] halt_mask,
    output logic              ack_req,
    output logic              clk_en,
    output logic              low_op,
    output logic              brk_pend,
    output logic [EVT_W-1:0]  evt_out,
    output logic              proto_err
);
    pm_state_e cur_state;
    logic      grant_fire;
    logic      early_err;
    logic      sleep_err;
    logic      deliver;
    logic      pend_any;

    stopclk_state_fsm #(.NUM_LP(NUM_LP)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_req     (halt_req),
        .deep_halt_en (deep_halt_en),
        .stop_clk_n   (stop_clk_n),
        .sleep_n      (sleep_n),
        .core_reset_n (core_reset_n),
        .snoop_start  (snoop_start),
        .snoop_done   (snoop_done),
        .wake_evt     (wake_evt),
        .ack_resp     (ack_resp),
        .grant_fire   (grant_fire),
        .pend_any     (pend_any),
        .state        (cur_state),
        .halt_mask    (halt_mask),
        .deliver      (deliver),
        .sleep_err    (sleep_err)
    );

    stopclk_grant_timer #(.NUM_LP(NUM_LP), .GRANT_DELAY(GRANT_DELAY)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .stop_clk_n   (stop_clk_n),
        .core_reset_n (core_reset_n),
        .arm_ok       (is_armable(cur_state)),
        .fire_ok      (is_armable(cur_state)),
        .ack_resp     (ack_resp),
        .ack_req      (ack_req),
        .grant_fire   (grant_fire),
        .early_err    (early_err)
    );

    stopclk_event_latch #(.EVT_W(EVT_W)) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .core_reset_n (core_reset_n),
        .latch_en     (is_grant(cur_state)),
        .deliver      (deliver),
        .wake_evt     (wake_evt),
        .pend_any     (pend_any),
        .brk_pend     (brk_pend),
        .evt_out      (evt_out)
    );

    // Output decode from the registered state
    assign state     = cur_state;
    assign clk_en    = (cur_state == ST_RUN) || (cur_state == ST_HALT_SNP)
                       || (cur_state == ST_DHALT_SNP) || (cur_state == ST_GRANT_SNP);
    assign low_op    = (cur_state == ST_DHALT) || (cur_state == ST_DHALT_SNP);
    assign proto_err = early_err || sleep_err;

    // R5
    gate_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_state == ST_GRANT) && snoop_start && !stop_clk_n && sleep_n && core_reset_n) |=> clk_en);

endmodule

// File: tb/stopclk_pm_ctrl_bench.sv
module stopclk_pm_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] halt_req;
    logic       deep_halt_en;
    logic       stop_clk_n;
    logic       sleep_n;
    logic       core_reset_n;
    logic       snoop_start;
    logic       snoop_done;
    logic [4:0] wake_evt;
    logic       ack_resp;
    logic [2:0] state;
    logic [1:0] halt_mask;
    logic       ack_req;
    logic       clk_en;
    logic       low_op;
    logic       brk_pend;
    logic [4:0] evt_out;
    logic       proto_err;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    stopclk_pm_ctrl u_stopclk_pm_ctrl (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .deep_halt_en(deep_halt_en),
        .stop_clk_n(stop_clk_n), .sleep_n(sleep_n), .core_reset_n(core_reset_n),
        .snoop_start(snoop_start), .snoop_done(snoop_done), .wake_evt(wake_evt),
        .ack_resp(ack_resp), .state(state), .halt_mask(halt_mask), .ack_req(ack_req),
        .clk_en(clk_en), .low_op(low_op), .brk_pend(brk_pend), .evt_out(evt_out),
        .proto_err(proto_err)
    );

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drives the full handshake and checks request and grant timing
    task automatic do_grant();
        stop_clk_n = 1'b0;
        step();
        chk("R6 req raised", ack_req, 1);
        ack_resp = 1'b1; step(); ack_resp = 1'b0;
        chk("R6 req after first response", ack_req, 1);
        ack_resp = 1'b1; step(); ack_resp = 1'b0;
        chk("R6 req after last response", ack_req, 0);
        step(19);
        chk("R7 not yet granted", state == 3'd5, 0);
        step();
        chk("R7 granted on time", state, 5);
        chk("R5 gate off in grant", clk_en, 0);
    endtask

    task automatic t_reset();
        chk("R1 state", state, 0);
        chk("R1 clk_en", clk_en, 1);
        chk("R1 ack_req", ack_req, 0);
        chk("R1 low_op", low_op, 0);
        chk("R1 brk_pend", brk_pend, 0);
        chk("R1 evt_out", evt_out, 0);
        chk("R1 proto_err", proto_err, 0);
    endtask

    task automatic t_plain_halt();
        deep_halt_en = 1'b0;
        halt_req = 2'b01; step(); halt_req = 2'b00;
        chk("R2 partial halt stays run", state, 0);
        chk("R2 mask partial", halt_mask, 2'b01);
        halt_req = 2'b10; step(); halt_req = 2'b00;
        chk("R2 full halt", state, 1);
        chk("R5 gate off in halt", clk_en, 0);
        chk("R5 no low op in halt", low_op, 0);
        wake_evt = 5'b00010; step(); wake_evt = '0;
        chk("R3 wake to run", state, 0);
        chk("R3 mask cleared", halt_mask, 0);
    endtask

    task automatic t_deep_halt();
        deep_halt_en = 1'b1;
        halt_req = 2'b11; step(); halt_req = 2'b00;
        chk("R2 deep halt", state, 2);
        chk("R5 low op in deep halt", low_op, 1);
        snoop_start = 1'b1; step(); snoop_start = 1'b0;
        chk("R4 deep snoop state", state, 4);
        chk("R5 gate on in snoop", clk_en, 1);
        chk("R4 low op kept in snoop", low_op, 1);
        step(2);
        chk("R4 waits for done", state, 4);
        snoop_done = 1'b1; step(); snoop_done = 1'b0;
        chk("R4 back to deep halt", state, 2);
        wake_evt = 5'b10000; step(); wake_evt = '0;
        chk("R3 deep wake to run", state, 0);
        deep_halt_en = 1'b0;
    endtask

    task automatic t_grant_events();
        do_grant();
        wake_evt = 5'b00001; step();
        wake_evt = 5'b01000; step();
        wake_evt = 5'b00001; step();
        wake_evt = '0;
        chk("R10 break flag", brk_pend, 1);
        chk("R10 no early delivery", evt_out, 0);
        snoop_start = 1'b1; step(); snoop_start = 1'b0;
        chk("R11 grant snoop", state, 6);
        chk("R5 gate on in grant snoop", clk_en, 1);
        chk("R10 flag held in snoop", brk_pend, 1);
        snoop_done = 1'b1; step(); snoop_done = 1'b0;
        chk("R11 back to grant", state, 5);
        stop_clk_n = 1'b1; step();
        chk("R8 return to run", state, 0);
        chk("R10 delivered bits", evt_out, 5'b01001);
        chk("R9 no error on legal release", proto_err, 0);
        step();
        chk("R10 pulse ends", evt_out, 0);
    endtask

    task automatic t_halt_return();
        halt_req = 2'b11; step(); halt_req = 2'b00;
        chk("R2 halt before stop", state, 1);
        do_grant();
        stop_clk_n = 1'b1; step();
        chk("R8 return to halt", state, 1);
        wake_evt = 5'b00100; step(); wake_evt = '0;
        chk("R3 wake after return", state, 0);
    endtask

    task automatic t_early_release();
        stop_clk_n = 1'b0; step();
        ack_resp = 1'b1; step(); ack_resp = 1'b0;
        ack_resp = 1'b1; step(); ack_resp = 1'b0;
        step(4);
        stop_clk_n = 1'b1; step();
        chk("R9 early release flagged", proto_err, 1);
        step();
        chk("R9 flag is one cycle", proto_err, 0);
        step(13);
        chk("R9 countdown still running", state, 0);
        step();
        chk("R9 grant reached on time", state, 5);
        step();
        chk("R8 released grant to run", state, 0);
    endtask

    task automatic t_sleep();
        do_grant();
        sleep_n = 1'b0; step();
        chk("R12 sleep entered", state, 7);
        chk("R5 gate off in sleep", clk_en, 0);
        step(3);
        chk("R12 quiet sleep no error", proto_err, 0);
        sleep_n = 1'b1; step();
        chk("R12 back to grant", state, 5);
        stop_clk_n = 1'b1; step();
        chk("R12 release after sleep", state, 0);
        chk("R12 release legal", proto_err, 0);
    endtask

    task automatic t_sleep_noise();
        do_grant();
        sleep_n = 1'b0; step();
        snoop_start = 1'b1; step(); snoop_start = 1'b0;
        chk("R13 snoop in sleep flagged", proto_err, 1);
        chk("R13 stays asleep", state, 7);
        step();
        chk("R13 flag one cycle", proto_err, 0);
        core_reset_n = 1'b0; sleep_n = 1'b1; stop_clk_n = 1'b1; step();
        core_reset_n = 1'b1;
        chk("R14 reset from sleep to run", state, 0);
        chk("R14 no error during reset", proto_err, 0);
    endtask

    task automatic t_reset_in_grant();
        do_grant();
        wake_evt = 5'b00010; step(); wake_evt = '0;
        chk("R10 held before reset", brk_pend, 1);
        core_reset_n = 1'b0; step(); core_reset_n = 1'b1;
        chk("R14 stays in grant", state, 5);
        chk("R14 events discarded", brk_pend, 0);
        stop_clk_n = 1'b1; step();
        chk("R14 run after release", state, 0);
        chk("R14 nothing delivered", evt_out, 0);
    endtask

    initial begin
        rst_n = 1'b0; halt_req = '0; deep_halt_en = 1'b0; stop_clk_n = 1'b1;
        sleep_n = 1'b1; core_reset_n = 1'b1; snoop_start = 1'b0; snoop_done = 1'b0;
        wake_evt = '0; ack_resp = 1'b0;
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_plain_halt();
        t_deep_halt();
        t_grant_events();
        t_halt_return();
        t_early_release();
        t_sleep();
        t_sleep_noise();
        t_reset_in_grant();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule